// File: doc/BRIEF.md
# Write-Protected Seconds Real-Time Clock Core

This core keeps time in whole seconds behind a small synchronous register port. A 32-bit seconds counter advances on an external one-pulse-per-second tick while the run bit is set. A 32-bit alarm register is compared against the counter. When the alarm is armed and the two values match, an alarm flag is raised. Each counted tick also raises a separate tick flag. Either flag can drive the single interrupt output through its own enable bit.

Every register that holds time or configuration is protected. Software first writes a 16-bit key to the key register and confirms that the key register's status bit reads 1. Only then can it write one protected register. That accepted write uses up the key. It also holds the ready bit low for a fixed number of cycles, which stands in for the time a slow clock domain would need to absorb the write. A protected write that arrives while the key is absent or while ready is low changes nothing. One protected register carries a power-down request bit, which drives an output pin.

Top module: `rtc_secs_core`

## Requirements
- R1: After reset, every register is zero, the key is absent and ready is 1. A read of the control register (offset 0x00) returns 0x80, and irq and pwr_down_req are 0.
- R2: A write to the key register (offset 0x3C) while ready is 1 grants the key when bits 15:0 equal 0xA55A and withdraws it for any other value. Bit 31 of the key register reads 1 exactly while the key is held; all other bits read 0.
- R3: A write to a protected register (offsets 0x00, 0x04, 0x08, 0x0C, 0x20) made without the key, or while ready is 0, leaves that register unchanged and does not drop ready. A key write while ready is 0 is also ignored.
- R4: A protected write made with the key while ready is 1 updates the register at that clock edge and withdraws the key.
- R5: After an accepted protected write, ready (control bit 7, read-only) reads 0 for exactly BUSY_CYCLES cycles (default 4) and then reads 1.
- R6: The seconds counter (offset 0x04) increments by one on each cycle with tick_1hz high, only while run (control bit 0) is 1. Otherwise it holds its value.
- R7: The seconds register (0x04) and the alarm register (0x08) hold full 32-bit values that read back exactly as written.
- R8: While alarm-arm (control bit 2) is 1 and seconds equals the alarm value, the alarm flag (control bit 4) is set on the next edge. Writing 0 to bit 4 clears it and writing 1 leaves it as it is. A set in the same cycle as a clear wins, and no flag is set while alarm-arm is 0.
- R9: The tick flag (control bit 6) is set by every counted tick. Writing 0 to bit 6 clears it.
- R10: irq equals (control bit 4 AND control bit 3) OR (control bit 6 AND control bit 5).
- R11: Bit 0 of the power register (offset 0x20) drives pwr_down_req, and its other bits read 0. The trim register (offset 0x0C) keeps bits 25:0 and reads 0 in bits 31:26.
- R12: When an accepted seconds write and a counted tick fall in the same cycle, the written value is stored and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request |
| pwr_down_req | output | 1 | Power-down request |

## Verification
Two pairs of events can land in the same cycle. The first pair is the hardware alarm set and a software write that clears the flag. The bench parks the counter on the alarm value and then writes 0 to the flag. Because the match still holds, the flag must read 1 afterwards. The second pair is a counted tick and an accepted seconds write. The bench drives both on one edge and expects the written value with no increment.

// File: rtl/rtc_pkg.sv
// Package: shared register offsets, control-bit positions and the control
// register type for the seconds RTC core.
package rtc_pkg;

    // Byte offsets of the registers (8-bit space)
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_SECS  = 8'h04;
    localparam logic [7:0] OFF_ALARM = 8'h08;
    localparam logic [7:0] OFF_TRIM  = 8'h0C;
    localparam logic [7:0] OFF_POWER = 8'h20;
    localparam logic [7:0] OFF_KEY   = 8'h3C;

    // Control register bit positions
    localparam int BIT_RUN   = 0;
    localparam int BIT_AARM  = 2;
    localparam int BIT_AIE   = 3;
    localparam int BIT_AFLAG = 4;
    localparam int BIT_TIE   = 5;
    localparam int BIT_TFLAG = 6;
    localparam int BIT_READY = 7;

    // Key register status bit
    localparam int BIT_KEY_OK = 31;

    // Trim register writable field
    localparam logic [31:0] TRIM_MASK = 32'h03FF_FFFF;

    // Software-visible control state (ready lives in the guard)
    typedef struct packed {
        logic tick_flag;
        logic tick_ie;
        logic alm_flag;
        logic alm_ie;
        logic alm_arm;
        logic run;
    } rtc_ctrl_t;

endpackage

// File: rtl/rtc_wr_guard.sv
// Module: rtc_wr_guard
// Decides whether a protected write is allowed to happen.
// - A key write made while ready is high grants or withdraws the key.
// - An accepted protected write uses up the key and starts a busy window
//   of BUSY_CYCLES cycles, during which ready reads low.
// Assumes: wr_fire is a single-cycle write strobe, and hit_key and
// hit_prot are mutually exclusive address decodes.
module rtc_wr_guard #(
    parameter int          BUSY_CYCLES = 4,
    parameter logic [15:0] UNLOCK_KEY  = 16'hA55A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_fire,
    input  logic        hit_key,
    input  logic        hit_prot,
    input  logic [15:0] key_data,
    output logic        unlocked,
    output logic        ready,
    output logic        prot_accept
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

    logic [CNT_W-1:0] busy_cnt;
    logic             key_write;

    assign ready       = (busy_cnt == '0);
    assign key_write   = wr_fire && hit_key && ready;
    assign prot_accept = wr_fire && hit_prot && ready && unlocked;

    // Key state: granted by a matching key write, cleared by any consumer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (key_write) begin
            unlocked <= (key_data == UNLOCK_KEY);
        end else if (prot_accept) begin
            unlocked <= 1'b0;
        end
    end

    // Busy window: loaded on an accepted write, counts down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (prot_accept) begin
            busy_cnt <= CNT_LOAD;
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/rtc_time_keeper.sv
// Module: rtc_time_keeper
// Holds the seconds counter and the alarm value, and compares the two.
// A load of the counter takes priority over a tick in the same cycle.
// Assumes: tick_1hz is a one-cycle pulse; the loads come from the write guard.
module rtc_time_keeper #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1hz,
    input  logic             run,
    input  logic             alm_arm,
    input  logic             sec_load,
    input  logic             alm_load,
    input  logic [SEC_W-1:0] wdata,
    output logic [SEC_W-1:0] seconds,
    output logic [SEC_W-1:0] alarm_val,
    output logic             count_evt,
    output logic             alarm_hit
);
    assign count_evt = tick_1hz && run;
    assign alarm_hit = alm_arm && (seconds == alarm_val);

    // Seconds counter: a load wins over a counted tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seconds <= '0;
        end else if (sec_load) begin
            seconds <= wdata;
        end else if (count_evt) begin
            seconds <= seconds + 1'b1;
        end
    end

    // Alarm value: written only through an accepted protected write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_val <= '0;
        end else if (alm_load) begin
            alarm_val <= wdata;
        end
    end

endmodule

// File: rtl/rtc_ctrl_flags.sv
// Module: rtc_ctrl_flags
// Control register with enable bits and two sticky event flags.
// - Each flag is cleared by writing 0 to it; writing 1 leaves it unchanged.
// - A hardware set wins over a software clear in the same cycle.
// - irq combines each flag with its own enable bit.
// Assumes: ctrl_wr is already qualified by the write guard.
module rtc_ctrl_flags (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [7:0]       wdata,
    input  logic             count_evt,
    input  logic             alarm_hit,
    output rtc_pkg::rtc_ctrl_t ctrl_q,
    output logic             irq
);
    import rtc_pkg::*;

    // Enable bits: plain read/write fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.run     <= 1'b0;
            ctrl_q.alm_arm <= 1'b0;
            ctrl_q.alm_ie  <= 1'b0;
            ctrl_q.tick_ie <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_q.run     <= wdata[BIT_RUN];
            ctrl_q.alm_arm <= wdata[BIT_AARM];
            ctrl_q.alm_ie  <= wdata[BIT_AIE];
            ctrl_q.tick_ie <= wdata[BIT_TIE];
        end
    end

    // Event flags: hardware set has priority over a write-0 clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.alm_flag  <= 1'b0;
            ctrl_q.tick_flag <= 1'b0;
        end else begin
            if (alarm_hit) begin
                ctrl_q.alm_flag <= 1'b1;
            end else if (ctrl_wr) begin
                ctrl_q.alm_flag <= ctrl_q.alm_flag & wdata[BIT_AFLAG];
            end
            if (count_evt) begin
                ctrl_q.tick_flag <= 1'b1;
            end else if (ctrl_wr) begin
                ctrl_q.tick_flag <= ctrl_q.tick_flag & wdata[BIT_TFLAG];
            end
        end
    end

    // Interrupt: each flag gated by its own enable
    always_comb begin
        irq = (ctrl_q.alm_flag && ctrl_q.alm_ie) || (ctrl_q.tick_flag && ctrl_q.tick_ie);
    end

endmodule

// File: rtl/rtc_secs_core.sv
// Module: rtc_secs_core (top)
// Register-mapped seconds real-time clock with write protection.
// - Decodes the register port and routes writes through rtc_wr_guard.
// - Holds the trim and power registers, and builds the read data.
// Assumes: the port is synchronous to clk; reads are combinational from
// bus_addr; unmapped offsets read 0 and ignore writes.
module rtc_secs_core #(
    parameter int          ADDR_W      = 8,
    parameter int          BUSY_CYCLES = 4,
    parameter logic [15:0] UNLOCK_KEY  = 16'hA55A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              pwr_down_req
);
    import rtc_pkg::*;

    localparam int DATA_W = 32;

    logic              wr_fire;
    logic              hit_ctrl, hit_secs, hit_alarm, hit_trim, hit_power, hit_key;
    logic              hit_prot;
    logic              unlocked, ready, prot_accept;
    logic              count_evt, alarm_hit;
    logic [DATA_W-1:0] seconds, alarm_val;
    logic [DATA_W-1:0] trim_q;
    logic              power_q;
    rtc_ctrl_t         ctrl_q;

    // Address decode of the register port
    always_comb begin
        wr_fire   = bus_sel && bus_we;
        hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_secs  = (bus_addr == ADDR_W'(OFF_SECS));
        hit_alarm = (bus_addr == ADDR_W'(OFF_ALARM));
        hit_trim  = (bus_addr == ADDR_W'(OFF_TRIM));
        hit_power = (bus_addr == ADDR_W'(OFF_POWER));
        hit_key   = (bus_addr == ADDR_W'(OFF_KEY));
        hit_prot  = hit_ctrl || hit_secs || hit_alarm || hit_trim || hit_power;
    end

    rtc_wr_guard #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .UNLOCK_KEY  (UNLOCK_KEY)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_fire),
        .hit_key     (hit_key),
        .hit_prot    (hit_prot),
        .key_data    (bus_wdata[15:0]),
        .unlocked    (unlocked),
        .ready       (ready),
        .prot_accept (prot_accept)
    );

    rtc_time_keeper #(
        .SEC_W (DATA_W)
    ) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .run       (ctrl_q.run),
        .alm_arm   (ctrl_q.alm_arm),
        .sec_load  (prot_accept && hit_secs),
        .alm_load  (prot_accept && hit_alarm),
        .wdata     (bus_wdata),
        .seconds   (seconds),
        .alarm_val (alarm_val),
        .count_evt (count_evt),
        .alarm_hit (alarm_hit)
    );

    rtc_ctrl_flags u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (prot_accept && hit_ctrl),
        .wdata     (bus_wdata[7:0]),
        .count_evt (count_evt),
        .alarm_hit (alarm_hit),
        .ctrl_q    (ctrl_q),
        .irq       (irq)
    );

    // Trim and power registers: protected plain storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_q  <= '0;
            power_q <= 1'b0;
        end else if (prot_accept) begin
            if (hit_trim)  trim_q  <= bus_wdata & TRIM_MASK;
            if (hit_power) power_q <= bus_wdata[0];
        end
    end

    assign pwr_down_req = power_q;

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[BIT_READY] = ready;
            bus_rdata[BIT_TFLAG] = ctrl_q.tick_flag;
            bus_rdata[BIT_TIE]   = ctrl_q.tick_ie;
            bus_rdata[BIT_AFLAG] = ctrl_q.alm_flag;
            bus_rdata[BIT_AIE]   = ctrl_q.alm_ie;
            bus_rdata[BIT_AARM]  = ctrl_q.alm_arm;
            bus_rdata[BIT_RUN]   = ctrl_q.run;
        end else if (hit_secs) begin
            bus_rdata = seconds;
        end else if (hit_alarm) begin
            bus_rdata = alarm_val;
        end else if (hit_trim) begin
            bus_rdata = trim_q;
        end else if (hit_power) begin
            bus_rdata[0] = power_q;
        end else if (hit_key) begin
            bus_rdata[BIT_KEY_OK] = unlocked;
        end
    end

endmodule

// File: rtl/rtc_secs_core_chk.sv
// Module: rtc_secs_core_chk
// Property checker bound to rtc_secs_core. It watches the bus, the guard
// state, the counter and the flags. A local counter measures the busy window.
module rtc_secs_core_chk #(
    parameter int ADDR_W      = 8,
    parameter int BUSY_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              unlocked,
    input logic              ready,
    input logic              prot_accept,
    input logic              run,
    input logic              alm_arm,
    input logic              alm_flag,
    input logic              tick_flag,
    input logic [31:0]       seconds,
    input logic [31:0]       alarm_val
);
    import rtc_pkg::*;

    localparam int LO_W = $clog2(BUSY_CYCLES + 2);

    logic            wr_any, wr_secs, wr_prot;
    logic [LO_W-1:0] lo_cnt;

    always_comb begin
        wr_any  = bus_sel && bus_we;
        wr_secs = wr_any && (bus_addr == ADDR_W'(OFF_SECS));
        wr_prot = wr_any && ((bus_addr == ADDR_W'(OFF_CTRL))  || (bus_addr == ADDR_W'(OFF_SECS)) ||
                             (bus_addr == ADDR_W'(OFF_ALARM)) || (bus_addr == ADDR_W'(OFF_TRIM)) ||
                             (bus_addr == ADDR_W'(OFF_POWER)));
    end

    // Length of the current stretch with ready low
    always_ff @(posedge clk) begin
        if (!rst_n)      lo_cnt <= '0;
        else if (ready)  lo_cnt <= '0;
        else             lo_cnt <= lo_cnt + 1'b1;
    end

    a_r1_ready_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> ready && !unlocked);

    a_r3_locked_write_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prot && !unlocked && ready) |=> ready);

    a_r3_rejected_secs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_secs && !(unlocked && ready) && !tick_1hz) |=> $stable(seconds));

    a_r4_key_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        prot_accept |=> (!unlocked && !ready));

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (lo_cnt == LO_W'(BUSY_CYCLES)));

    a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= LO_W'(BUSY_CYCLES));

    a_r6_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(prot_accept && wr_secs)) |=> $stable(seconds));

    a_r6_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && run && !(prot_accept && wr_secs)) |=> (seconds == $past(seconds) + 32'd1));

    a_r8_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_arm && (seconds == alarm_val)) |=> alm_flag);

    a_r9_tick_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && run) |=> tick_flag);

    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_accept && wr_secs) |=> (seconds == $past(bus_wdata)));

endmodule

bind rtc_secs_core rtc_secs_core_chk #(
    .ADDR_W      (ADDR_W),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1hz    (tick_1hz),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .unlocked    (unlocked),
    .ready       (ready),
    .prot_accept (prot_accept),
    .run         (ctrl_q.run),
    .alm_arm     (ctrl_q.alm_arm),
    .alm_flag    (ctrl_q.alm_flag),
    .tick_flag   (ctrl_q.tick_flag),
    .seconds     (seconds),
    .alarm_val   (alarm_val)
);

// File: tb/rtc_secs_core_test.sv
`timescale 1ns/1ps
// Bench for rtc_secs_core: driver tasks queue expected items, and a
// monitor pops each one and compares it with the observed port.
module rtc_secs_core_test;

    localparam int BUSY = 4;
    localparam logic [7:0] A_CTRL = 8'h00, A_SECS = 8'h04, A_ALARM = 8'h08,
                           A_TRIM = 8'h0C, A_POWER = 8'h20, A_KEY = 8'h3C;
    localparam int K_RDATA = 0, K_IRQ = 1, K_PWR = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, pwr_down_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    int          kind_q[$];
    string       tag_q[$];
    event        mon_ev;

    rtc_secs_core uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_1hz     (tick_1hz),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq          (irq),
        .pwr_down_req (pwr_down_req)
    );

    always #2.5 clk = ~clk;

    // Monitor: pop the oldest expectation and compare it with the port
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                logic [31:0] e;
                logic [31:0] act;
                int k;
                string t;
                e = exp_q.pop_front();
                k = kind_q.pop_front();
                t = tag_q.pop_front();
                act = (k == K_RDATA) ? bus_rdata : (k == K_IRQ) ? {31'b0, irq} : {31'b0, pwr_down_req};
                checks++;
                if (act !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    // Driver: queue an expectation and present the read address
    task automatic expect_port(input int kind, input logic [7:0] addr, input logic [31:0] e, input string tag);
        bus_sel = (kind == K_RDATA);
        bus_we = 1'b0;
        bus_addr = addr;
        exp_q.push_back(e);
        kind_q.push_back(kind);
        tag_q.push_back(tag);
        #1;
        -> mon_ev;
        #0.5;
        bus_sel = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] addr, input logic [31:0] e, input string tag);
        expect_port(K_RDATA, addr, e, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Protected write with the key, then wait out the busy window
    task automatic pw(input logic [7:0] addr, input logic [31:0] d);
        wr(A_KEY, 32'h0000_A55A);
        wr(addr, d);
        idle(BUSY);
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd(A_CTRL, 32'h80, "R1 ctrl");
        chk_rd(A_SECS, 32'h0, "R1 seconds");
        chk_rd(A_KEY, 32'h0, "R1 key");
        expect_port(K_IRQ, A_CTRL, 32'h0, "R1 irq");
        expect_port(K_PWR, A_CTRL, 32'h0, "R1 pwr");

        // R3 write without key is dropped, ready stays high
        wr(A_SECS, 32'h1234);
        chk_rd(A_SECS, 32'h0, "R3 locked seconds");
        chk_rd(A_CTRL, 32'h80, "R3 no busy");

        // R2 grant, withdraw, grant
        wr(A_KEY, 32'h0000_A55A);
        chk_rd(A_KEY, 32'h8000_0000, "R2 granted");
        wr(A_KEY, 32'h0000_1111);
        chk_rd(A_KEY, 32'h0, "R2 withdrawn");
        wr(A_KEY, 32'h0000_A55A);

        // R4/R7/R5 accepted write, key consumed, busy window
        wr(A_SECS, 32'hFFFF_FFF0);
        chk_rd(A_SECS, 32'hFFFF_FFF0, "R7 seconds rw");
        chk_rd(A_KEY, 32'h0, "R4 key consumed");
        chk_rd(A_CTRL, 32'h00, "R5 busy start");
        idle(BUSY - 1);
        chk_rd(A_CTRL, 32'h00, "R5 busy last");
        idle(1);
        chk_rd(A_CTRL, 32'h80, "R5 ready again");

        // R3 writes during busy are dropped
        wr(A_KEY, 32'h0000_A55A);
        wr(A_SECS, 32'd5);
        wr(A_KEY, 32'h0000_A55A);
        idle(BUSY);
        chk_rd(A_KEY, 32'h0, "R3 key during busy");
        wr(A_SECS, 32'd9);
        chk_rd(A_SECS, 32'd5, "R3 busy/locked seconds");

        // R6 counting only while run
        tick(); tick();
        chk_rd(A_SECS, 32'd5, "R6 stopped");
        pw(A_CTRL, 32'h01);
        tick(); tick(); tick();
        chk_rd(A_SECS, 32'd8, "R6 counting");
        chk_rd(A_CTRL, 32'hC1, "R9 tick flag set");

        // R10 tick interrupt, R9 clear by writing 0
        expect_port(K_IRQ, A_CTRL, 32'h0, "R10 irq masked");
        pw(A_CTRL, 32'h61);
        expect_port(K_IRQ, A_CTRL, 32'h1, "R10 tick irq");
        chk_rd(A_CTRL, 32'hE1, "R9 write 1 keeps flag");
        pw(A_CTRL, 32'h21);
        chk_rd(A_CTRL, 32'hA1, "R9 flag cleared");
        expect_port(K_IRQ, A_CTRL, 32'h0, "R10 irq dropped");

        // R8 alarm match
        pw(A_ALARM, 32'd10);
        chk_rd(A_ALARM, 32'd10, "R7 alarm rw");
        pw(A_CTRL, 32'h0D);
        tick(); tick();
        chk_rd(A_CTRL, 32'hCD, "R8 flag one cycle later");
        idle(1);
        chk_rd(A_CTRL, 32'hDD, "R8 alarm flag set");
        expect_port(K_IRQ, A_CTRL, 32'h1, "R10 alarm irq");

        // R8 set wins over clear while match persists
        pw(A_CTRL, 32'h0D);
        chk_rd(A_CTRL, 32'h9D, "R8 set beats clear");
        tick();
        pw(A_CTRL, 32'h0D);
        chk_rd(A_CTRL, 32'h8D, "R8 cleared after match");
        expect_port(K_IRQ, A_CTRL, 32'h0, "R10 irq off");

        // R12 seconds load and tick in the same cycle
        wr(A_KEY, 32'h0000_A55A);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_SECS; bus_wdata = 32'd100;
        tick_1hz = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick_1hz = 1'b0;
        chk_rd(A_SECS, 32'd100, "R12 load wins");
        idle(BUSY);

        // R8 no flag while disarmed
        pw(A_CTRL, 32'h01);
        pw(A_ALARM, 32'd100);
        idle(2);
        chk_rd(A_CTRL, 32'h81, "R8 disarmed no flag");

        // R11 power and trim
        pw(A_POWER, 32'hFFFF_FFFF);
        expect_port(K_PWR, A_CTRL, 32'h1, "R11 pwr_down_req");
        chk_rd(A_POWER, 32'h1, "R11 power read");
        pw(A_TRIM, 32'hFFFF_FFFF);
        chk_rd(A_TRIM, 32'h03FF_FFFF, "R11 trim mask");

        // R7 full width alarm
        pw(A_ALARM, 32'hDEAD_BEEF);
        chk_rd(A_ALARM, 32'hDEAD_BEEF, "R7 alarm 32-bit");

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule